// File: doc/BRIEF.md
# JTAG Command Sequence Driver

This block sits between a debug controller and an IEEE 1149.1 test access port. It accepts high-level commands one at a time over a valid/ready handshake. It turns each command into a paced train of TCK pulses, with TMS and TDI set up while TCK is low. There are four kinds of command: an instruction-register shift, a data-register shift, a one-pulse dwell in Run-Test/Idle, and a five-pulse reset. A shift command carries a bit count and a data vector. The vector is sent most significant bit first, so a concatenation of fields leaves the port leftmost field first.

The driver keeps its own copy of the TAP state. For each command it walks TMS from wherever the TAP currently rests. Shift commands run on to Shift-IR or Shift-DR, send their bits with TMS high on the last one, and stop in the matching Update state. The route out of Update goes directly to Select-DR-Scan and never parks in Run-Test/Idle, because every TCK spent there clocks the target. TDO is sampled on every shift pulse. When a shift command finishes, the captured bits are returned on a result port, earliest bit at index 0.

Top module: `jtag_seq_driver`

## Requirements
- R1: `cmd_ready` is high after reset and whenever no command is running. It drops in the cycle after a command is accepted and stays low until that command's last TCK has ended. `cmd_kind` encodes 0 = instruction shift, 1 = data shift, 2 = idle dwell, 3 = reset. Shift commands carry a length from 1 to MAX_LEN.
- R2: An instruction shift ends in Update-IR. From Test-Logic-Reset it uses 6+len TCK rising edges. From Run-Test/Idle or either Update state it uses 5+len. Exactly len of those edges occur in Shift-IR, and none in Shift-DR.
- R3: During a shift command the TAP enters Run-Test/Idle only when the command starts in Test-Logic-Reset, and then for exactly one edge. From Run-Test/Idle or an Update state the TAP does not enter it at all.
- R4: A data shift ends in Update-DR. From Test-Logic-Reset it uses 5+len edges. From Run-Test/Idle or either Update state it uses 4+len. Exactly len of those edges occur in Shift-DR, and none in Shift-IR.
- R5: Shift data leaves on TDI most significant bit first, so the target's received bits equal `cmd_data[len-1:0]`. TMS is high on the final shift bit and low on the others.
- R6: After a shift command, `res_valid` is high for one cycle. In that cycle `res_data` bit i holds the TDO value sampled on the i-th shift edge, bits at or above len are zero, and `res_len` equals len. Idle and reset commands raise no result.
- R7: An idle-dwell command issued from Test-Logic-Reset, Run-Test/Idle or an Update state produces exactly one TCK rising edge, and that edge leaves the TAP in Run-Test/Idle. Back-to-back dwells each add one such edge.
- R8: A reset command produces exactly five TCK edges, all with TMS high, and leaves the TAP in Test-Logic-Reset.
- R9: TCK is low while idle. TMS and TDI change only while TCK is low. Consecutive rising edges within a command are exactly 2*TCK_HALF clock cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Driver can take a command |
| cmd_kind | input | 2 | Command kind (see R1) |
| cmd_len | input | 7 | Shift length in bits |
| cmd_data | input | 72 | Shift data, sent MSB of the used field first |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |
| res_valid | output | 1 | One-cycle result strobe |
| res_len | output | 7 | Number of captured bits |
| res_data | output | 72 | Captured TDO bits, first at index 0 |

## Verification
The assertions take three things for granted. Shift commands arrive with a length between 1 and MAX_LEN. The target TAP leaves reset in Test-Logic-Reset together with the driver's tracker. `cmd_kind` uses only the four listed codes. The bench releases reset with its own TAP model in Test-Logic-Reset and offers only legal lengths from 1 to 72. It drops `cmd_valid` in the cycle after acceptance, so no command is offered while one is running.

// File: rtl/jsd_pkg.sv
package jsd_pkg;

    typedef enum logic [1:0] {
        K_IR    = 2'd0,
        K_DR    = 2'd1,
        K_IDLE  = 2'd2,
        K_RESET = 2'd3
    } cmd_kind_e;

    typedef enum logic [3:0] {
        ST_TLR     = 4'd0,
        ST_RTI     = 4'd1,
        ST_SEL_DR  = 4'd2,
        ST_CAP_DR  = 4'd3,
        ST_SH_DR   = 4'd4,
        ST_EX1_DR  = 4'd5,
        ST_PAU_DR  = 4'd6,
        ST_EX2_DR  = 4'd7,
        ST_UPD_DR  = 4'd8,
        ST_SEL_IR  = 4'd9,
        ST_CAP_IR  = 4'd10,
        ST_SH_IR   = 4'd11,
        ST_EX1_IR  = 4'd12,
        ST_PAU_IR  = 4'd13,
        ST_EX2_IR  = 4'd14,
        ST_UPD_IR  = 4'd15
    } tap_state_e;

    // Standard 16-state controller transition on a TCK rising edge.
    function automatic tap_state_e tap_next(tap_state_e s, logic tms);
        tap_state_e n;
        n = ST_TLR;
        case (s)
            ST_TLR:    n = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: n = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  n = tms ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: n = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: n = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: n = tms ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: n = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: n = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  n = tms ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: n = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: n = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: n = tms ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: n = tms ? ST_SEL_DR : ST_RTI;
            default:   n = ST_TLR;
        endcase
        return n;
    endfunction

    function automatic logic is_shift_target(tap_state_e s, cmd_kind_e k);
        return (k == K_IR && s == ST_SH_IR) || (k == K_DR && s == ST_SH_DR);
    endfunction

    function automatic logic is_update(tap_state_e s);
        return (s == ST_UPD_IR) || (s == ST_UPD_DR);
    endfunction

    // One-step lookahead: TMS value that moves toward the command's goal.
    // Update states route straight to Select-DR for shift commands.
    function automatic logic route_tms(tap_state_e s, cmd_kind_e k, logic last);
        logic t;
        t = 1'b1;
        case (s)
            ST_TLR:    t = 1'b0;
            ST_RTI:    t = (k == K_IDLE) ? 1'b0 : 1'b1;
            ST_SEL_DR: t = (k == K_DR) ? 1'b0 : 1'b1;
            ST_SEL_IR: t = (k == K_IR) ? 1'b0 : 1'b1;
            ST_CAP_DR: t = (k == K_DR) ? 1'b0 : 1'b1;
            ST_CAP_IR: t = (k == K_IR) ? 1'b0 : 1'b1;
            ST_SH_DR:  t = (k == K_DR) ? last : 1'b1;
            ST_SH_IR:  t = (k == K_IR) ? last : 1'b1;
            ST_UPD_DR,
            ST_UPD_IR: t = (k == K_IDLE) ? 1'b0 : 1'b1;
            default:   t = 1'b1;
        endcase
        return t;
    endfunction

endpackage

// File: rtl/jsd_tck_gen.sv
module jsd_tck_gen #(
    parameter int TCK_HALF = 2,
    localparam int PH_W = $clog2(2 * TCK_HALF)
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tck,
    output logic load_stb,
    output logic rise_stb,
    output logic end_stb
);
    logic [PH_W-1:0] ph_q;
    logic            tck_q;

    localparam logic [PH_W-1:0] PH_RISE = PH_W'(TCK_HALF - 1);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(2 * TCK_HALF - 1);

    always_comb begin
        load_stb = run && (ph_q == '0);
        rise_stb = run && (ph_q == PH_RISE);
        end_stb  = run && (ph_q == PH_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            ph_q  <= '0;
            tck_q <= 1'b0;
        end else begin
            ph_q <= (ph_q == PH_LAST) ? '0 : ph_q + PH_W'(1);
            if (ph_q == PH_RISE)      tck_q <= 1'b1;
            else if (ph_q == PH_LAST) tck_q <= 1'b0;
        end
    end

    assign tck = tck_q;

    initial begin
        assert (TCK_HALF >= 2) else $error("TCK_HALF must be at least 2");
    end
endmodule

// File: rtl/jsd_tap_track.sv
module jsd_tap_track
    import jsd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       rise_stb,
    input  logic       tms,
    output tap_state_e state
);
    tap_state_e state_q;

    always_ff @(posedge clk) begin
        if (rst)           state_q <= ST_TLR;
        else if (rise_stb) state_q <= tap_next(state_q, tms);
    end

    assign state = state_q;
endmodule

// File: rtl/jsd_tdo_cap.sv
module jsd_tdo_cap #(
    parameter int MAX_LEN = 72,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               shift_stb,
    input  logic               tdo,
    output logic [MAX_LEN-1:0] cap
);
    logic [MAX_LEN-1:0] cap_q;
    logic [LEN_W-1:0]   idx_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cap_q <= '0;
            idx_q <= '0;
        end else if (shift_stb && idx_q < LEN_W'(MAX_LEN)) begin
            cap_q[idx_q] <= tdo;
            idx_q        <= idx_q + LEN_W'(1);
        end
    end

    assign cap = cap_q;
endmodule

// File: rtl/jsd_cmd_seq.sv
module jsd_cmd_seq
    import jsd_pkg::*;
#(
    parameter int MAX_LEN    = 72,
    parameter int RESET_TCKS = 5,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    input  logic [1:0]         cmd_kind,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [MAX_LEN-1:0] cmd_data,
    output logic               cmd_ready,
    input  logic               load_stb,
    input  logic               rise_stb,
    input  logic               end_stb,
    input  tap_state_e         state,
    output logic               run,
    output logic               tms,
    output logic               tdi,
    output logic               accept,
    output logic               shift_stb,
    output logic               step_done,
    output logic               is_shift_cmd,
    output logic [LEN_W-1:0]   len_o
);
    localparam int RC_W = $clog2(RESET_TCKS + 1);

    logic               active_q, done_q, tms_q, tdi_q;
    cmd_kind_e          kind_q;
    logic [LEN_W-1:0]   len_q, cnt_q;
    logic [MAX_LEN-1:0] sh_q;
    logic [RC_W-1:0]    rcnt_q;
    logic               in_shift, last_bit, finish;
    tap_state_e         nxt;

    assign accept = cmd_valid && !active_q;

    always_comb begin
        in_shift = is_shift_target(state, kind_q);
        last_bit = (cnt_q == len_q - LEN_W'(1));
        nxt      = tap_next(state, tms_q);
        case (kind_q)
            K_IR:    finish = (nxt == ST_UPD_IR);
            K_DR:    finish = (nxt == ST_UPD_DR);
            K_IDLE:  finish = (nxt == ST_RTI);
            default: finish = (rcnt_q == RC_W'(RESET_TCKS - 1));
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            tms_q    <= 1'b0;
            tdi_q    <= 1'b0;
            kind_q   <= K_IDLE;
            len_q    <= '0;
            cnt_q    <= '0;
            sh_q     <= '0;
            rcnt_q   <= '0;
        end else begin
            if (accept) begin
                active_q <= 1'b1;
                done_q   <= 1'b0;
                kind_q   <= cmd_kind_e'(cmd_kind);
                len_q    <= cmd_len;
                cnt_q    <= '0;
                rcnt_q   <= '0;
                // left-align the used field so the top bit leaves first
                sh_q     <= cmd_data << (MAX_LEN - int'(cmd_len));
            end
            if (load_stb) begin
                tms_q <= (kind_q == K_RESET) ? 1'b1 : route_tms(state, kind_q, last_bit);
                tdi_q <= in_shift ? sh_q[MAX_LEN-1] : 1'b0;
            end
            if (rise_stb) begin
                if (in_shift) begin
                    sh_q  <= sh_q << 1;
                    cnt_q <= cnt_q + LEN_W'(1);
                end
                if (kind_q == K_RESET) rcnt_q <= rcnt_q + RC_W'(1);
                if (finish) done_q <= 1'b1;
            end
            if (end_stb && done_q) begin
                active_q <= 1'b0;
                done_q   <= 1'b0;
            end
        end
    end

    assign cmd_ready    = !active_q;
    assign run          = active_q;
    assign tms          = tms_q;
    assign tdi          = tdi_q;
    assign shift_stb    = rise_stb && in_shift;
    assign step_done    = end_stb && done_q;
    assign is_shift_cmd = (kind_q == K_IR) || (kind_q == K_DR);
    assign len_o        = len_q;

    // R1: input assumption on legal shift lengths
    assert_len_legal_R1: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready && cmd_kind[1] == 1'b0)
            |-> (cmd_len >= LEN_W'(1) && cmd_len <= LEN_W'(MAX_LEN)));

    // R3: a shift command may step into Run-Test/Idle only from Test-Logic-Reset
    assert_idle_only_from_reset_R3: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && is_shift_cmd && tap_next(state, tms_q) == ST_RTI) |-> (state == ST_TLR));

    // R3: leaving an Update state during a shift command heads for Select-DR
    assert_update_exit_R3: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && is_shift_cmd && is_update(state)) |-> tms_q);

    // R5: TMS marks exactly the last shift bit
    assert_last_bit_tms_R5: assert property (@(posedge clk) disable iff (rst)
        shift_stb |-> (tms_q == (cnt_q == len_q - LEN_W'(1))));

    // R8: every reset pulse carries TMS high
    assert_reset_tms_R8: assert property (@(posedge clk) disable iff (rst)
        (rise_stb && kind_q == K_RESET) |-> tms_q);
endmodule

// File: rtl/jtag_seq_driver.sv
module jtag_seq_driver
    import jsd_pkg::*;
#(
    parameter int MAX_LEN    = 72,
    parameter int TCK_HALF   = 2,
    parameter int RESET_TCKS = 5,
    localparam int LEN_W = $clog2(MAX_LEN + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_kind,
    input  logic [LEN_W-1:0]   cmd_len,
    input  logic [MAX_LEN-1:0] cmd_data,
    output logic               tck,
    output logic               tms,
    output logic               tdi,
    input  logic               tdo,
    output logic               res_valid,
    output logic [LEN_W-1:0]   res_len,
    output logic [MAX_LEN-1:0] res_data
);
    logic               run, load_stb, rise_stb, end_stb;
    logic               accept, shift_stb, step_done, is_shift_cmd;
    logic [LEN_W-1:0]   len_cur;
    logic [MAX_LEN-1:0] cap;
    tap_state_e         tap_state;

    logic               res_valid_q;
    logic [LEN_W-1:0]   res_len_q;
    logic [MAX_LEN-1:0] res_data_q;

    jsd_tck_gen #(.TCK_HALF(TCK_HALF)) u_tck (
        .clk(clk), .rst(rst), .run(run), .tck(tck),
        .load_stb(load_stb), .rise_stb(rise_stb), .end_stb(end_stb)
    );

    jsd_tap_track u_track (
        .clk(clk), .rst(rst), .rise_stb(rise_stb), .tms(tms), .state(tap_state)
    );

    jsd_cmd_seq #(.MAX_LEN(MAX_LEN), .RESET_TCKS(RESET_TCKS)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_len(cmd_len),
        .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .load_stb(load_stb), .rise_stb(rise_stb), .end_stb(end_stb),
        .state(tap_state), .run(run), .tms(tms), .tdi(tdi),
        .accept(accept), .shift_stb(shift_stb), .step_done(step_done),
        .is_shift_cmd(is_shift_cmd), .len_o(len_cur)
    );

    jsd_tdo_cap #(.MAX_LEN(MAX_LEN)) u_cap (
        .clk(clk), .rst(rst), .clear(accept), .shift_stb(shift_stb),
        .tdo(tdo), .cap(cap)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid_q <= 1'b0;
            res_len_q   <= '0;
            res_data_q  <= '0;
        end else begin
            res_valid_q <= step_done && is_shift_cmd;
            if (step_done && is_shift_cmd) begin
                res_len_q  <= len_cur;
                res_data_q <= cap;
            end
        end
    end

    assign res_valid = res_valid_q;
    assign res_len   = res_len_q;
    assign res_data  = res_data_q;

    // R9: pin values hold while TCK is high
    assert_pins_stable_R9: assert property (@(posedge clk) disable iff (rst)
        tck |-> ($stable(tms) && $stable(tdi)));

    // R9: no clocking while no command is running
    assert_tck_idle_low_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_ready |-> !tck);

    // R6: a result lasts a single cycle and follows a running command
    assert_res_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> ($past(!cmd_ready) && cmd_ready));

    assert_res_single_R6: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid);
endmodule

// File: tb/jtag_seq_driver_tb_top.sv
`timescale 1ns/1ps
module jtag_seq_driver_tb_top;
    localparam int ML   = 72;
    localparam int HALF = 2;
    localparam int LW   = 7;

    // bench-side TAP state codes
    localparam int S_TLR = 0,  S_RTI = 1,  S_SDS = 2,  S_CDR = 3,  S_SHD = 4,
                   S_E1D = 5,  S_PD  = 6,  S_E2D = 7,  S_UDR = 8,  S_SIS = 9,
                   S_CIR = 10, S_SHI = 11, S_E1I = 12, S_PI  = 13, S_E2I = 14,
                   S_UIR = 15;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cmd_valid = 1'b0;
    logic [1:0] cmd_kind = 2'd0;
    logic [LW-1:0] cmd_len = '0;
    logic [ML-1:0] cmd_data = '0;
    logic cmd_ready, tck, tms, tdi, res_valid;
    logic tdo = 1'b0;
    logic [LW-1:0] res_len;
    logic [ML-1:0] res_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    jtag_seq_driver #(.MAX_LEN(ML), .TCK_HALF(HALF), .RESET_TCKS(5)) dut_i (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_kind(cmd_kind), .cmd_len(cmd_len), .cmd_data(cmd_data),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .res_valid(res_valid), .res_len(res_len), .res_data(res_data)
    );

    // ---------------- target TAP model ----------------
    int m_state = S_TLR;
    int n_edge = 0, n_rti = 0, n_ir = 0, n_dr = 0, n_ones = 0, bad_period = 0;
    logic [ML-1:0] rx = '0;
    logic [ML-1:0] cur_pat = '0;
    int pat_base = 0;
    realtime last_rise = 0.0;

    function automatic int nx(int s, logic t);
        case (s)
            S_TLR: return t ? S_TLR : S_RTI;
            S_RTI: return t ? S_SDS : S_RTI;
            S_SDS: return t ? S_SIS : S_CDR;
            S_CDR: return t ? S_E1D : S_SHD;
            S_SHD: return t ? S_E1D : S_SHD;
            S_E1D: return t ? S_UDR : S_PD;
            S_PD:  return t ? S_E2D : S_PD;
            S_E2D: return t ? S_UDR : S_SHD;
            S_UDR: return t ? S_SDS : S_RTI;
            S_SIS: return t ? S_TLR : S_CIR;
            S_CIR: return t ? S_E1I : S_SHI;
            S_SHI: return t ? S_E1I : S_SHI;
            S_E1I: return t ? S_UIR : S_PI;
            S_PI:  return t ? S_E2I : S_PI;
            S_E2I: return t ? S_UIR : S_SHI;
            default: return t ? S_SDS : S_RTI;
        endcase
    endfunction

    always @(posedge tck) begin
        if (last_rise > 0.0 && ($realtime - last_rise) < (2.0 * HALF * 10.0))
            bad_period++;
        last_rise = $realtime;
        n_edge++;
        if (tms) n_ones++;
        if (m_state == S_SHI) begin n_ir++; rx = {rx[ML-2:0], tdi}; end
        if (m_state == S_SHD) begin n_dr++; rx = {rx[ML-2:0], tdi}; end
        m_state = nx(m_state, tms);
        if (m_state == S_RTI) n_rti++;
    end

    always @(negedge tck) begin
        if (m_state == S_SHI || m_state == S_SHD) begin
            int k;
            k = n_ir + n_dr - pat_base;
            tdo <= (k >= 0 && k < ML) ? cur_pat[k] : 1'b0;
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string req, input string what,
                       input logic [ML-1:0] act, input logic [ML-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [ML-1:0] mk(input int len);
        if (len >= ML) return '1;
        return (ML'(1) << len) - ML'(1);
    endfunction

    task automatic run_cmd(input int kind, input int len);
        int s0, e0, r0, i0, d0, o0, sg, exp_e, exp_s, exp_r;
        logic [ML-1:0] data, pat, m;
        bit got_res;
        logic [ML-1:0] rd;
        logic [LW-1:0] rl;

        data = {8'(len * 3 + kind), 64'h0123_4567_89AB_CDEF ^ (64'(len) * 64'h9E37_79B9_7F4A_7C15)};
        pat  = {data[35:0], data[71:36]} ^ 72'hFF_0F0F_F0F0_3C3C_C3C3;
        m    = mk(len);
        s0 = m_state; e0 = n_edge; r0 = n_rti; i0 = n_ir; d0 = n_dr; o0 = n_ones;
        pat_base = n_ir + n_dr;
        cur_pat  = pat;

        @(negedge clk);
        cmd_valid = 1'b1; cmd_kind = 2'(kind); cmd_len = LW'(len); cmd_data = data;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(cmd_ready == 1'b0, "R1", "ready low while busy", ML'(cmd_ready), '0);
        got_res = 0; rd = '0; rl = '0;
        while (!cmd_ready) begin
            @(negedge clk);
        end
        if (res_valid) begin got_res = 1; rd = res_data; rl = res_len; end
        chk(tck == 1'b0, "R9", "tck low after command", ML'(tck), '0);

        sg = (s0 == S_TLR) ? 0 : (s0 == S_RTI) ? 1 : 2;
        case (kind)
            0: begin exp_e = ((sg == 0) ? 6 : 5) + len; exp_s = S_UIR; end
            1: begin exp_e = ((sg == 0) ? 5 : 4) + len; exp_s = S_UDR; end
            2: begin exp_e = 1; exp_s = S_RTI; end
            default: begin exp_e = 5; exp_s = S_TLR; end
        endcase
        exp_r = (kind < 2) ? ((sg == 0) ? 1 : 0) : (kind == 2) ? 1 : 0;

        if (kind == 0) begin
            chk(n_edge - e0 == exp_e, "R2", "ir edge count", ML'(n_edge - e0), ML'(exp_e));
            chk(m_state == exp_s, "R2", "ir end state", ML'(m_state), ML'(exp_s));
            chk(n_ir - i0 == len && n_dr == d0, "R2", "ir shift edges", ML'(n_ir - i0), ML'(len));
        end else if (kind == 1) begin
            chk(n_edge - e0 == exp_e, "R4", "dr edge count", ML'(n_edge - e0), ML'(exp_e));
            chk(m_state == exp_s, "R4", "dr end state", ML'(m_state), ML'(exp_s));
            chk(n_dr - d0 == len && n_ir == i0, "R4", "dr shift edges", ML'(n_dr - d0), ML'(len));
        end else if (kind == 2) begin
            chk(n_edge - e0 == 1 && m_state == S_RTI, "R7", "dwell edge/state",
                ML'(n_edge - e0), ML'(1));
        end else begin
            chk(n_edge - e0 == 5 && n_ones - o0 == 5, "R8", "reset tms-high edges",
                ML'(n_ones - o0), ML'(5));
            chk(m_state == S_TLR, "R8", "reset end state", ML'(m_state), ML'(S_TLR));
        end

        if (kind < 2) begin
            chk(n_rti - r0 == exp_r, "R3", "idle entries in shift", ML'(n_rti - r0), ML'(exp_r));
            chk((rx & m) == (data & m), "R5", "tdi bits msb first", rx & m, data & m);
            chk(got_res && rl == LW'(len), "R6", "result strobe/len", ML'(rl), ML'(len));
            chk(rd == (pat & m), "R6", "captured tdo", rd, pat & m);
        end else begin
            chk(!got_res, "R6", "no result for non-shift", ML'(got_res), '0);
            if (kind == 2)
                chk(n_rti - r0 == 1, "R7", "dwell idle entries", ML'(n_rti - r0), ML'(1));
        end
    endtask

    // ---------------- stimulus ----------------
    int lens[6] = '{1, 2, 7, 32, 33, 72};

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", ML'(cmd_ready), ML'(1));
        chk(tck == 1'b0 && res_valid == 1'b0, "R9", "tck idle after reset", ML'(tck), '0);

        for (int sg = 0; sg < 4; sg++) begin
            for (int kd = 0; kd < 2; kd++) begin
                for (int li = 0; li < 6; li++) begin
                    case (sg)
                        0: run_cmd(3, 0);
                        1: run_cmd(2, 0);
                        2: run_cmd(0, 4);
                        default: run_cmd(1, 3);
                    endcase
                    run_cmd(kd, lens[li]);
                end
            end
        end

        // R7: back-to-back dwells, each adds one edge in Run-Test/Idle
        begin
            int r0;
            r0 = n_rti;
            run_cmd(2, 0); run_cmd(2, 0); run_cmd(2, 0);
            chk(n_rti - r0 == 3, "R7", "three dwells", ML'(n_rti - r0), ML'(3));
        end
        // R8: reset from Run-Test/Idle, then a dwell from reset
        run_cmd(3, 0);
        run_cmd(2, 0);
        run_cmd(3, 0);

        chk(bad_period == 0, "R9", "tck period", ML'(bad_period), '0);

        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule